// File: doc/BRIEF.md
# Burst Memory Address Sequencer

This block produces the word address presented to a synchronous burst memory. On a rising clock edge it captures an external address, together with the combined state of three chip-select inputs, whenever one of two active-low address strobes is accepted. After that load, the two lowest address bits come from an internal burst count. The count steps by one on each clock edge where the active-low advance input is low, so up to three further beat addresses follow the first before the sequence wraps.

A mode pin chooses between linear order and interleaved order. In linear order the start offset and the count are added modulo four. In interleaved order they are XORed. The mode pin is not registered, so it acts on the address output at once.

Control is a two-state machine. `SEQ_IDLE` is entered at reset. The transition `load_first` moves it to `SEQ_BURST` on the first accepted strobe. `SEQ_BURST` keeps itself through the transition `reload`, taken on every later strobe, and through `hold_or_step` otherwise. A strobe accepted in a cycle always takes precedence over an advance in that same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` and `sel_out` are 0. An advance has no effect until the first accepted strobe.
- R2: A low `strobe_ctrl_n` loads `addr_in` and the select state on the next rising edge, whatever the chip-select inputs are.
- R3: A low `strobe_proc_n` loads only while `ce1_n` is low. While `ce1_n` is high it is ignored: the address and `sel_out` are unchanged.
- R4: If both strobes are low in the same cycle, exactly one load of `addr_in` takes place. The processor strobe takes precedence when it is accepted. When `ce1_n` is high it is not accepted, so the controller strobe performs the load, with the select state deasserted.
- R5: At a load, `sel_out` becomes 1 exactly when `ce1_n` is 0, `ce2` is 1 and `ce3_n` is 0. Between loads `sel_out` holds its value.
- R6: With no strobe, a low `adv_n` steps the burst count n by one. The address bits above bit 1 never change without a load.
- R7: With `mode_il` = 0 (linear), the low two address bits equal (start + n) mod 4. The sequence wraps to the start offset after four beats.
- R8: With `mode_il` = 1 (interleaved), the low two address bits equal start XOR (n mod 4).
- R9: `mode_il` is asynchronous. A change on it alters `addr_out` without waiting for a clock edge.
- R10: An accepted strobe during a burst reloads the address and clears n, even when `adv_n` is low in the same cycle.
- R11: With both strobes and `adv_n` high, `addr_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | External word address |
| strobe_proc_n | input | 1 | Processor address strobe, active low, gated by ce1_n |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary chip select, active low |
| ce2 | input | 1 | Secondary chip select, active high |
| ce3_n | input | 1 | Tertiary chip select, active low |
| mode_il | input | 1 | Burst order: 0 linear, 1 interleaved (asynchronous) |
| addr_out | output | ADDR_W | Current beat address |
| sel_out | output | 1 | Registered combined chip select |

## Verification
The main sweep loads every start offset in both orders and then advances five times. The fifth beat shows whether the count wraps to the start offset or runs on, and the cases with odd start offsets tell addition apart from XOR. Further patterns cover the following: an advance before any load, both strobes at once with the primary select on and off, the processor strobe while the primary select is off, a reload in the middle of a burst together with an advance, idle cycles, and a toggle of the mode pin between clock edges. Together these tell apart the two strobes' gating, load-versus-advance precedence and the asynchronous mode path.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_t;
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl (
    input  logic strobe_proc_n,
    input  logic strobe_ctrl_n,
    input  logic ce1_n,
    output logic take_load
);
    logic proc_ok;

    // Processor strobe counts only while the primary select is active;
    // it has precedence, otherwise the controller strobe decides.
    always_comb begin
        proc_ok = !strobe_proc_n && !ce1_n;
        if (proc_ok) take_load = 1'b1;
        else         take_load = !strobe_ctrl_n;
    end
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  step,
    output logic [BURST_BITS-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (clr)  count <= '0;
        else if (step) count <= count + 1'b1;
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] start,
    input  logic [BURST_BITS-1:0] count,
    input  logic                  interleave,
    output logic [BURST_BITS-1:0] low_out
);
    logic [BURST_BITS-1:0] lin_val;
    logic [BURST_BITS-1:0] xor_val;

    genvar b;
    generate
        for (b = 0; b < BURST_BITS; b++) begin : g_xor
            assign xor_val[b] = start[b] ^ count[b];
        end
    endgenerate

    always_comb begin
        lin_val = start + count;
        low_out = interleave ? xor_val : lin_val;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_proc_n,
    input  logic              strobe_ctrl_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              mode_il,
    output logic [ADDR_W-1:0] addr_out,
    output logic              sel_out
);
    localparam int HI_W = ADDR_W - BURST_BITS;

    seq_state_t            state_q;
    seq_state_t            state_d;
    logic                  take_load;
    logic                  step_en;
    logic [ADDR_W-1:0]     base_q;
    logic                  sel_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] low_bits;
    logic [HI_W-1:0]       high_bits;

    burst_load_ctl u_load (
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .ce1_n         (ce1_n),
        .take_load     (take_load)
    );

    // Next state: load_first, reload, hold_or_step
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (take_load) state_d = SEQ_BURST;
            SEQ_BURST: state_d = SEQ_BURST;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Output registers: captured base address and select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            sel_q  <= 1'b0;
        end else if (take_load) begin
            base_q <= addr_in;
            sel_q  <= !ce1_n && ce2 && !ce3_n;
        end
    end

    assign step_en = (state_q == SEQ_BURST) && !adv_n && !take_load;

    burst_counter #(.BURST_BITS(BURST_BITS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take_load),
        .step  (step_en),
        .count (cnt_q)
    );

    burst_order_map #(.BURST_BITS(BURST_BITS)) u_map (
        .start      (base_q[BURST_BITS-1:0]),
        .count      (cnt_q),
        .interleave (mode_il),
        .low_out    (low_bits)
    );

    assign high_bits = base_q[ADDR_W-1:BURST_BITS];
    assign addr_out  = {high_bits, low_bits};
    assign sel_out   = sel_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W     = 20,
    parameter int BURST_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_proc_n,
    input logic              strobe_ctrl_n,
    input logic              adv_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              mode_il,
    input logic [ADDR_W-1:0] addr_out,
    input logic              sel_out
);
    logic load_seen;
    logic sel_want;

    assign load_seen = !strobe_ctrl_n || (!strobe_proc_n && !ce1_n);
    assign sel_want  = !ce1_n && ce2 && !ce3_n;

    // R2
    ctrl_load_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_ctrl_n |=> addr_out[ADDR_W-1:BURST_BITS] == $past(addr_in[ADDR_W-1:BURST_BITS]));

    // R10
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_seen |=> addr_out[BURST_BITS-1:0] == $past(addr_in[BURST_BITS-1:0]));

    // R3
    proc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n && ce1_n && strobe_ctrl_n && adv_n)
            |=> ($stable(addr_out) && $stable(sel_out)) || !$stable(mode_il));

    // R5
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_seen |=> sel_out == $past(sel_want));

    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_seen |=> $stable(sel_out));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc_n && strobe_ctrl_n) |=> $stable(addr_out[ADDR_W-1:BURST_BITS]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc_n && strobe_ctrl_n && adv_n) |=> $stable(addr_out) || !$stable(mode_il));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_proc_n(strobe_proc_n),
    .strobe_ctrl_n(strobe_ctrl_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .mode_il(mode_il), .addr_out(addr_out), .sel_out(sel_out)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_proc_n = 1'b1;
    logic          strobe_ctrl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ce1_n = 1'b0;
    logic          ce2 = 1'b1;
    logic          ce3_n = 1'b0;
    logic          mode_il = 1'b0;
    logic [AW-1:0] addr_out;
    logic          sel_out;

    int checks = 0;
    int fails  = 0;

    burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_proc_n(strobe_proc_n),
        .strobe_ctrl_n(strobe_ctrl_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .mode_il(mode_il), .addr_out(addr_out), .sel_out(sel_out)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s, input int n);
        logic [1:0] nn;
        nn = 2'(n % 4);
        return m ? (s ^ nn) : 2'(s + nn);
    endfunction

    task automatic ctrl_load(input logic [AW-1:0] a);
        addr_in = a; strobe_ctrl_n = 1'b0;
        tick();
        strobe_ctrl_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        logic [AW-1:0] a;
        #12;
        // R1 reset state
        check("R1 addr", addr_out, '0);
        check("R1 sel", {7'd0, sel_out}, 8'd0);
        rst_n = 1'b1;
        tick();
        adv_n = 1'b0; tick(); tick(); adv_n = 1'b1;
        check("R1 adv before load", addr_out, '0);

        // R7/R8 sweep: both orders, all start offsets, five advances (wrap)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                mode_il = m[0];
                a = {6'(m * 16 + s * 3 + 5), 2'(s)};
                ctrl_load(a);
                check("R2 load", addr_out, a);
                for (int n = 1; n <= 5; n++) begin
                    adv_n = 1'b0; tick(); adv_n = 1'b1;
                    check(m ? "R8 interleaved" : "R7 linear", addr_out, {a[7:2], exp_low(m[0], 2'(s), n)});
                end
            end
        end

        // R11 hold and R6 upper bits
        mode_il = 1'b0;
        ctrl_load(8'hA1);
        adv_n = 1'b0; tick(); adv_n = 1'b1;
        tick(); tick(); tick();
        check("R11 hold", addr_out, 8'hA2);
        check("R6 upper", {2'b00, addr_out[7:2]}, {2'b00, 6'(8'hA1 >> 2)});

        // R9 asynchronous mode: start 1, n=1 -> linear 2, interleaved 0
        mode_il = 1'b1; #1;
        check("R9 mode to interleaved", addr_out, 8'hA0);
        mode_il = 1'b0; #1;
        check("R9 mode to linear", addr_out, 8'hA2);
        #1;

        // R10 reload mid-burst together with an advance
        addr_in = 8'h5E; strobe_ctrl_n = 1'b0; adv_n = 1'b0;
        tick();
        strobe_ctrl_n = 1'b1;
        check("R10 reload clears count", addr_out, 8'h5E);
        tick(); adv_n = 1'b1;
        check("R10 step after reload", addr_out, 8'h5F);

        // R3 processor strobe ignored while ce1_n high
        ce1_n = 1'b1; addr_in = 8'h33; strobe_proc_n = 1'b0;
        tick();
        strobe_proc_n = 1'b1;
        check("R3 ignored addr", addr_out, 8'h5F);
        check("R3 ignored sel", {7'd0, sel_out}, 8'd1);
        ce1_n = 1'b0; strobe_proc_n = 1'b0;
        tick();
        strobe_proc_n = 1'b1;
        check("R3 accepted", addr_out, 8'h33);

        // R2/R5 controller strobe with selects off
        ce1_n = 1'b1;
        ctrl_load(8'h48);
        check("R2 load with ce1_n high", addr_out, 8'h48);
        check("R5 sel off", {7'd0, sel_out}, 8'd0);
        ce1_n = 1'b0; ce2 = 1'b0;
        ctrl_load(8'h49);
        check("R5 ce2 low sel", {7'd0, sel_out}, 8'd0);
        ce2 = 1'b1; ce3_n = 1'b1;
        ctrl_load(8'h4A);
        check("R5 ce3_n high sel", {7'd0, sel_out}, 8'd0);
        ce3_n = 1'b0;
        ctrl_load(8'h4B);
        check("R5 all on sel", {7'd0, sel_out}, 8'd1);
        tick(); tick();
        check("R5 sel held", {7'd0, sel_out}, 8'd1);

        // R4 both strobes
        addr_in = 8'hC6; strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b0;
        tick();
        check("R4 both ce1 on addr", addr_out, 8'hC6);
        check("R4 both ce1 on sel", {7'd0, sel_out}, 8'd1);
        ce1_n = 1'b1; addr_in = 8'h1D;
        tick();
        strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; ce1_n = 1'b0;
        check("R4 both ce1 off addr", addr_out, 8'h1D);
        check("R4 both ce1 off sel", {7'd0, sel_out}, 8'd0);

        finish_run();
    end
endmodule